// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block sits on the receive side of an Ethernet MAC and gives a pass or drop verdict for every frame. When a frame starts, the block looks at its destination address and the current filter modes, and it keeps the result. When the frame ends, it combines that result with the error flags reported for the frame. The verdict is a single-cycle pulse in the cycle after end-of-frame.

A run/stop control gates the receive path. When reception is requested, the receiver starts running. When the request is withdrawn, the receiver stops. If a frame is in progress at that moment, it stops only after that frame has ended.

Filter modes and the operating mode are configuration that can change only while the receiver is stopped. The block ignores configuration writes made at any other time. The modes are:
- promiscuous
- accept all multicast
- pass errored frames
- accept all unicast

Top module: `rxf_accept_filter`

## Requirements
- R1: After synchronous reset, `rx_state` is 00 (stopped), `verdict_valid` is 0, `loopback` is 0, and every filter mode is off.
- R2: With all filter modes off, a good frame whose destination equals `station_addr` is accepted, and a good frame to any other unicast address is dropped.
- R3: With promiscuous mode on, every good frame is accepted whatever its destination.
- R4: A good frame sent to the all-ones broadcast address is accepted under every mode setting.
- R5: With accept-all-multicast on, every good frame is accepted whose destination has bit 40 set. Bit 40 is the least significant bit of the first octet, which is `dest_addr[47:40]`.
- R6: With accept-all-unicast on, every good frame is accepted whose destination has bit 40 clear.
- R7: A frame is errored when any of `err_runt`, `err_crc` or `err_trunc` is 1 at end-of-frame. With pass-bad off, an errored frame is always dropped. With pass-bad on, an errored frame is accepted exactly when its address would be accepted.
- R8: `verdict_valid` is 1 for exactly the one cycle after each `eof` that closes a frame opened by `sof`. `verdict_accept` is 0 whenever `verdict_valid` is 0. An `eof` with no open frame gives no verdict.
- R9: When `rx_run` is 1 while the receiver is stopped, `rx_state` becomes 01 (running) one cycle later.
- R10: When `rx_run` is 0 while running and no frame is open, `rx_state` becomes 00 one cycle later. If a frame is open, `rx_state` becomes 10 (draining), and it moves to 00 in the cycle after that frame's `eof`. That frame still gets its normal verdict.
- R11: A frame whose `sof` arrives while `rx_state` is not 01 gets a verdict pulse with `verdict_accept` = 0.
- R12: A `cfg_wr` pulse updates the four filter modes and the operating mode only while `rx_state` is 00. Otherwise it has no effect.
- R13: `cfg_opmode` 00 selects normal operation and 01 selects loopback, which drives `loopback` to 1. The reserved codes 10 and 11 leave the operating mode unchanged, but the same write still updates the filter modes.
- R14: The block samples `station_addr` and the filter modes at `sof`. Changes to `station_addr` between `sof` and `eof` do not alter that frame's verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_run | input | 1 | Receive run request (1 run, 0 stop) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_promisc | input | 1 | Promiscuous mode value |
| cfg_mcast_all | input | 1 | Accept-all-multicast value |
| cfg_pass_bad | input | 1 | Pass-errored-frames value |
| cfg_pass_ucast | input | 1 | Accept-all-unicast value |
| cfg_opmode | input | 2 | Operating mode code (00 normal, 01 loopback) |
| station_addr | input | 48 | Own station MAC address |
| sof | input | 1 | Frame start strobe, with `dest_addr` valid |
| dest_addr | input | 48 | Destination address of the starting frame |
| eof | input | 1 | Frame end strobe, with error flags valid |
| err_runt | input | 1 | Frame too short |
| err_crc | input | 1 | Frame check sequence mismatch |
| err_trunc | input | 1 | Frame truncated |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | 1 pass, 0 drop; qualified by `verdict_valid` |
| rx_state | output | 2 | 00 stopped, 01 running, 10 draining |
| loopback | output | 1 | Operating mode is loopback |

## Verification
The assertions check the following on every cycle:
- a verdict follows only an end-of-frame strobe, and an accept never appears without a verdict;
- an errored frame is accepted only under a sampled pass-bad mode, and an unadmitted frame is never accepted;
- the run/stop state moves as required;
- configuration stays frozen outside the stopped state, and reserved operating codes are never taken.

Only the bench scenarios can show that the address decision itself is right for every combination of modes, address classes and error flags. They also show that a stop waits for the open frame to drain, that a frame started while stopped is dropped, and that a station address changed mid-frame does not alter the verdict.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int OCTET_W = 8;

    typedef enum logic [1:0] {
        RX_STOPPED  = 2'b00,
        RX_RUNNING  = 2'b01,
        RX_DRAINING = 2'b10
    } rx_state_e;

    typedef enum logic [1:0] {
        OPM_NORMAL   = 2'b00,
        OPM_LOOPBACK = 2'b01,
        OPM_RSVD_A   = 2'b10,
        OPM_RSVD_B   = 2'b11
    } opmode_e;

    typedef struct packed {
        logic promisc;
        logic mcast_all;
        logic pass_bad;
        logic pass_ucast;
    } filt_mode_t;

    typedef struct packed {
        logic is_station;
        logic is_bcast;
        logic is_mcast;
    } addr_class_t;

    function automatic logic opmode_legal(input logic [1:0] code);
        return code[1] == 1'b0;
    endfunction

    function automatic logic addr_pass(input filt_mode_t m, input addr_class_t c);
        return m.promisc | c.is_station | c.is_bcast
             | (m.mcast_all & c.is_mcast)
             | (m.pass_ucast & ~c.is_mcast);
    endfunction

endpackage

// File: rtl/rxf_mode_regs.sv
module rxf_mode_regs
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  filt_mode_t wr_mode,
    input  logic [1:0] wr_opmode,
    input  rx_state_e  state,
    output filt_mode_t mode_q,
    output opmode_e    opmode_q
);

    logic wr_ok;
    assign wr_ok = wr_en && (state == RX_STOPPED);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            opmode_q <= OPM_NORMAL;
        end else if (wr_ok) begin
            mode_q <= wr_mode;
            if (opmode_legal(wr_opmode))
                opmode_q <= opmode_e'(wr_opmode);
        end
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (state != RX_STOPPED) |=> $stable(mode_q) && $stable(opmode_q)); // R12

    AST_RSVD_OPMODE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_opmode[1]) |=> $stable(opmode_q)); // R13

endmodule

// File: rtl/rxf_addr_class.sv
module rxf_addr_class
    import rxf_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] dest,
    input  logic [ADDR_W-1:0] station,
    output addr_class_t       cls
);

    localparam int NOCT   = ADDR_W / OCTET_W;
    localparam int MC_BIT = ADDR_W - OCTET_W;

    logic [NOCT-1:0] oct_eq;
    logic [NOCT-1:0] oct_ones;

    for (genvar i = 0; i < NOCT; i++) begin : g_oct
        assign oct_eq[i]   = dest[i*OCTET_W +: OCTET_W] == station[i*OCTET_W +: OCTET_W];
        assign oct_ones[i] = &dest[i*OCTET_W +: OCTET_W];
    end

    assign cls.is_station = &oct_eq;
    assign cls.is_bcast   = &oct_ones;
    assign cls.is_mcast   = dest[MC_BIT];

    always_comb begin
        AST_BCAST_IS_MCAST: assert (!cls.is_bcast || cls.is_mcast); // R4
    end

endmodule

// File: rtl/rxf_run_ctrl.sv
module rxf_run_ctrl
    import rxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run_req,
    input  logic      frame_open,
    input  logic      eof,
    output rx_state_e state
);

    rx_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            RX_STOPPED:  if (run_req) nxt = RX_RUNNING;
            RX_RUNNING:  if (!run_req) nxt = frame_open ? RX_DRAINING : RX_STOPPED;
            RX_DRAINING: begin
                if (run_req)  nxt = RX_RUNNING;
                else if (eof) nxt = RX_STOPPED;
            end
            default:     nxt = RX_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= RX_STOPPED;
        else     state <= nxt;
    end

    AST_START_RUN: assert property (@(posedge clk) disable iff (rst)
        (state == RX_STOPPED && run_req) |=> (state == RX_RUNNING)); // R9

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == RX_RUNNING && !run_req && !frame_open) |=> (state == RX_STOPPED)); // R10

    AST_STOP_WAITS: assert property (@(posedge clk) disable iff (rst)
        (state == RX_RUNNING && !run_req && frame_open) |=> (state == RX_DRAINING)); // R10

    AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state == RX_DRAINING && eof && !run_req) |=> (state == RX_STOPPED)); // R10

endmodule

// File: rtl/rxf_accept_filter.sv
module rxf_accept_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_run,
    input  logic              cfg_wr,
    input  logic              cfg_promisc,
    input  logic              cfg_mcast_all,
    input  logic              cfg_pass_bad,
    input  logic              cfg_pass_ucast,
    input  logic [1:0]        cfg_opmode,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              sof,
    input  logic [ADDR_W-1:0] dest_addr,
    input  logic              eof,
    input  logic              err_runt,
    input  logic              err_crc,
    input  logic              err_trunc,
    output logic              verdict_valid,
    output logic              verdict_accept,
    output logic [1:0]        rx_state,
    output logic              loopback
);

    filt_mode_t  mode_q;
    filt_mode_t  wr_mode;
    opmode_e     opmode_q;
    rx_state_e   state;
    addr_class_t cls;

    logic frame_open;
    logic admitted_q;
    logic snap_addr_ok;
    logic snap_pass_bad;
    logic frame_err;

    assign wr_mode = '{promisc:    cfg_promisc,
                       mcast_all:  cfg_mcast_all,
                       pass_bad:   cfg_pass_bad,
                       pass_ucast: cfg_pass_ucast};

    rxf_mode_regs u_mode (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr),
        .wr_mode   (wr_mode),
        .wr_opmode (cfg_opmode),
        .state     (state),
        .mode_q    (mode_q),
        .opmode_q  (opmode_q)
    );

    rxf_addr_class #(.ADDR_W(ADDR_W)) u_cls (
        .dest    (dest_addr),
        .station (station_addr),
        .cls     (cls)
    );

    rxf_run_ctrl u_run (
        .clk        (clk),
        .rst        (rst),
        .run_req    (rx_run),
        .frame_open (frame_open),
        .eof        (eof),
        .state      (state)
    );

    assign frame_err = err_runt | err_crc | err_trunc;

    // Frame context: opened at sof (which wins over a same-cycle eof closing the prior frame)
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_open    <= 1'b0;
            admitted_q    <= 1'b0;
            snap_addr_ok  <= 1'b0;
            snap_pass_bad <= 1'b0;
        end else if (sof) begin
            frame_open    <= 1'b1;
            admitted_q    <= (state == RX_RUNNING);
            snap_addr_ok  <= addr_pass(mode_q, cls);
            snap_pass_bad <= mode_q.pass_bad;
        end else if (eof) begin
            frame_open    <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_valid  <= 1'b0;
            verdict_accept <= 1'b0;
        end else if (eof && frame_open) begin
            verdict_valid  <= 1'b1;
            verdict_accept <= admitted_q & snap_addr_ok & (~frame_err | snap_pass_bad);
        end else begin
            verdict_valid  <= 1'b0;
            verdict_accept <= 1'b0;
        end
    end

    assign rx_state = state;
    assign loopback = (opmode_q == OPM_LOOPBACK);

    AST_VERDICT_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |-> $past(eof && frame_open)); // R8

    AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        verdict_accept |-> verdict_valid); // R8

    AST_ERR_GATED: assert property (@(posedge clk) disable iff (rst)
        verdict_accept |-> $past(snap_pass_bad || !frame_err)); // R7

    AST_UNADMITTED_DROP: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && !$past(admitted_q)) |-> !verdict_accept); // R11

endmodule

// File: tb/sim_rxf_accept_filter.sv
module sim_rxf_accept_filter;
    import rxf_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, rx_run, cfg_wr;
    logic        cfg_promisc, cfg_mcast_all, cfg_pass_bad, cfg_pass_ucast;
    logic [1:0]  cfg_opmode;
    logic [47:0] station_addr, dest_addr;
    logic        sof, eof, err_runt, err_crc, err_trunc;
    logic        verdict_valid, verdict_accept, loopback;
    logic [1:0]  rx_state;

    rxf_accept_filter u0 (.*);

    localparam logic [47:0] STA  = 48'h02_11_22_33_44_55;
    localparam logic [47:0] UNI  = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [47:0] MC   = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] BC   = 48'hFF_FF_FF_FF_FF_FF;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [3:0] m_mode;   // {promisc, mcast_all, pass_bad, pass_ucast}

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [3:0] m, input logic [1:0] op);
        {cfg_promisc, cfg_mcast_all, cfg_pass_bad, cfg_pass_ucast} = m;
        cfg_opmode = op;
        cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0;
    endtask

    function automatic logic exp_accept(input logic [3:0] m, input logic [47:0] da,
                                        input logic [47:0] sa, input logic [2:0] err);
        logic a;
        a = m[3] | (da == sa) | (da == BC) | (m[2] & da[40]) | (m[0] & ~da[40]);
        return a & ((err == 3'b000) | m[1]);
    endfunction

    // sof at one negedge, eof the next, verdict sampled one negedge later
    task automatic frame(input logic [47:0] da, input logic [2:0] err,
                         input logic exp_acc, input string req);
        sof = 1'b1; dest_addr = da;
        tick();
        sof = 1'b0; eof = 1'b1; {err_runt, err_crc, err_trunc} = err;
        tick();
        chk({req, " verdict_valid"}, verdict_valid, 1'b1);
        chk({req, " verdict_accept"}, verdict_accept, exp_acc);
        eof = 1'b0; {err_runt, err_crc, err_trunc} = 3'b000;
        tick();
        chk("R8 pulse ends", verdict_valid, 1'b0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        summary();
    end

    initial begin
        logic [47:0] das [4];
        string tag;
        das[0] = STA; das[1] = UNI; das[2] = MC; das[3] = BC;
        rst = 1'b1; rx_run = 1'b0; cfg_wr = 1'b0;
        {cfg_promisc, cfg_mcast_all, cfg_pass_bad, cfg_pass_ucast} = 4'b0;
        cfg_opmode = 2'b00; station_addr = STA; dest_addr = '0;
        sof = 0; eof = 0; err_runt = 0; err_crc = 0; err_trunc = 0;
        m_mode = 4'b0;
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 rx_state", rx_state, 2'b00);
        chk("R1 verdict_valid", verdict_valid, 1'b0);
        chk("R1 loopback", loopback, 1'b0);

        // R9 start
        rx_run = 1'b1;
        tick();
        chk("R9 running", rx_state, 2'b01);

        // R1 / R2 modes off after reset
        frame(UNI, 3'b000, 1'b0, "R1 R2 other unicast");
        frame(STA, 3'b000, 1'b1, "R2 station");

        // R8 eof with no open frame
        eof = 1'b1; tick(); eof = 1'b0; tick();
        chk("R8 stray eof", verdict_valid, 1'b0);

        // R12 write while running ignored (promisc + loopback requested)
        write_cfg(4'b1000, 2'b01);
        tick();
        chk("R12 opmode ignored", loopback, 1'b0);
        frame(UNI, 3'b000, 1'b0, "R12 promisc ignored");

        // R10 stop mid-frame
        sof = 1'b1; dest_addr = STA;
        tick();
        sof = 1'b0; rx_run = 1'b0;
        tick();
        chk("R10 draining", rx_state, 2'b10);
        // R14 station changed mid-frame
        station_addr = UNI;
        eof = 1'b1;
        tick();
        chk("R10 stopped after eof", rx_state, 2'b00);
        chk("R14 verdict_valid", verdict_valid, 1'b1);
        chk("R14 accept with sampled station", verdict_accept, 1'b1);
        eof = 1'b0; station_addr = STA;
        tick();

        // R13 opmode codes while stopped
        write_cfg(4'b1000, 2'b01); tick();
        chk("R13 loopback set", loopback, 1'b1);
        write_cfg(4'b0000, 2'b10); tick();
        chk("R13 reserved 10 ignored", loopback, 1'b1);
        write_cfg(4'b1000, 2'b11); tick();
        chk("R13 reserved 11 ignored", loopback, 1'b1);
        write_cfg(4'b1000, 2'b00); tick();
        chk("R13 normal", loopback, 1'b0);
        m_mode = 4'b1000;

        // R11 frame while stopped, promisc on: still dropped
        frame(STA, 3'b000, 1'b0, "R11 stopped frame");

        // R10 idle stop
        rx_run = 1'b1; tick();
        chk("R9 restart", rx_state, 2'b01);
        rx_run = 1'b0; tick();
        chk("R10 idle stop", rx_state, 2'b00);

        // Sweep: all modes x address classes x error flags
        for (int m = 0; m < 16; m++) begin
            rx_run = 1'b0; tick();
            write_cfg(m[3:0], 2'b00);
            m_mode = m[3:0];
            rx_run = 1'b1; tick();
            chk("R9 running", rx_state, 2'b01);
            for (int d = 0; d < 4; d++) begin
                for (int e = 0; e < 8; e++) begin
                    if (e != 0)             tag = "R7";
                    else if (d == 3)        tag = "R4";
                    else if (m_mode[3])     tag = "R3";
                    else if (d == 2)        tag = "R5";
                    else if (d == 1)        tag = "R6";
                    else                    tag = "R2";
                    frame(das[d], e[2:0], exp_accept(m_mode, das[d], STA, e[2:0]), tag);
                end
            end
        end
        summary();
    end

endmodule